// File: doc/BRIEF.md
# Configurable-Width Lane Steering RAM

This block is the data path of a small storage array built from sixteen one-bit lanes. The array has 64 locations. Software-invisible wiring picks the external data width: 16, 8, 4, 2 or 1 bits. A four-bit fold vector sets the width. Each bit of the vector merges one level of a binary tree of lane junctions. On a write, the narrow input word fans out to the lanes that the column decoder enables. On a read, the enabled lanes collapse onto the low output pins. The column decoder lives outside the block and appears here as a lane-select mask.

A request carries an address, a direction and write data over a valid/ready handshake. A read produces one response word over a second valid/ready handshake. The response sits in a one-entry output register, and back-pressure works through that register:
- `req_ready` is high whenever that register is empty or is being drained in the same cycle.
- A stalled response keeps its data steady until the consumer takes it.
- Writes complete on acceptance and return nothing.

Top module: `vw_lane_ram`

## Requirements
- R1: `fold_ctl` must be one of five codes, and each code sets the external width w. The codes are 4'b0000 for w=16, 4'b0001 for w=8, 4'b0011 for w=4, 4'b0111 for w=2 and 4'b1111 for w=1. Bit k merges tree level k+1, which halves the number of lanes that reach the pins.
- R2: On an accepted write in width w, every lane i whose `lane_sel[i]` is 1 stores `req_wdata[i mod w]`. Input pins at index w and above are ignored.
- R3: On an accepted write, lanes whose `lane_sel` bit is 0 keep their stored value.
- R4: An accepted read in width w drives output pin p (p < w) with the OR of the stored bits of the enabled lanes i that satisfy i mod w = p. Lanes that are not enabled contribute 0.
- R5: On a read response, output pins at index w and above read 0.
- R6: An accepted read raises `rsp_valid` on the next clock edge, with the data from R4 in `rsp_data`.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_data` does not change.
- R8: `req_ready` is 1 exactly when `rsp_valid` is 0 or `rsp_ready` is 1. A request is accepted only in a cycle where both `req_valid` and `req_ready` are 1.
- R9: An accepted write does not create a response.
- R10: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fold_ctl | input | 4 | Level merge controls; the thermometer code selects the width |
| lane_sel | input | 16 | Lane enables from the column decoder |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Location address |
| req_wdata | input | 16 | Write word; only pins below w are used |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 16 | Read word; pins at index w and above are 0 |

## Verification
The properties assume two things about the inputs:
- `fold_ctl` holds a thermometer code whenever `req_valid` is high.
- The decoder enables at most one lane per residue class i mod w. Without this, R4 would merge two stored bits onto one pin.

The stimulus draws the fold code only from the five legal values. It builds each lane mask by choosing at most one lane in every residue class, and sometimes leaves a class empty. It toggles `rsp_ready` at random, so that stalls of several cycles occur while new requests wait.

// File: rtl/vw_pkg.sv
package vw_pkg;
  localparam int unsigned VW_LANES = 16;
  localparam int unsigned VW_DEPTH = 64;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } vw_op_e;
endpackage

// File: rtl/vw_spread.sv
// Write fan-out: walk the junction tree from the narrowest level outward.
module vw_spread #(
  parameter int LANES  = 16,
  localparam int LEVELS = $clog2(LANES)
) (
  input  logic [LEVELS-1:0] fold,
  input  logic [LANES-1:0]  pins,
  output logic [LANES-1:0]  lanes
);
  always_comb begin
    logic [LANES-1:0] cur;
    cur = pins;
    for (int l = LEVELS - 1; l >= 0; l--) begin
      if (fold[l]) begin
        for (int i = 0; i < LANES; i++) begin
          if (i >= (LANES >> (l + 1)) && i < (LANES >> l))
            cur[i] = cur[i - (LANES >> (l + 1))];
        end
      end
    end
    lanes = cur;
  end
endmodule

// File: rtl/vw_gather.sv
// Read collapse: each merged level ORs the upper half of the live span onto the lower half.
module vw_gather #(
  parameter int LANES  = 16,
  localparam int LEVELS = $clog2(LANES)
) (
  input  logic [LEVELS-1:0] fold,
  input  logic [LANES-1:0]  sel,
  input  logic [LANES-1:0]  lanes,
  output logic [LANES-1:0]  pins
);
  always_comb begin
    logic [LANES-1:0] cur;
    logic [LANES-1:0] nxt;
    cur = lanes & sel;
    for (int l = 0; l < LEVELS; l++) begin
      nxt = cur;
      if (fold[l]) begin
        for (int i = 0; i < LANES; i++) begin
          if (i < (LANES >> (l + 1)))
            nxt[i] = cur[i] | cur[(i + (LANES >> (l + 1))) % LANES];
          else
            nxt[i] = 1'b0;
        end
      end
      cur = nxt;
    end
    pins = cur;
  end
endmodule

// File: rtl/vw_store.sv
// One storage column per lane, each with its own write enable.
module vw_store #(
  parameter int LANES = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] wmask,
  input  logic [LANES-1:0] wbits,
  output logic [LANES-1:0] rbits
);
  for (genvar g = 0; g < LANES; g++) begin : g_col
    logic [DEPTH-1:0] col;
    always_ff @(posedge clk) begin
      if (we && wmask[g]) col[addr] <= wbits[g];
    end
    assign rbits[g] = col[addr];
  end
endmodule

// File: rtl/vw_lane_ram.sv
module vw_lane_ram
  import vw_pkg::*;
#(
  parameter int LANES = VW_LANES,
  parameter int DEPTH = VW_DEPTH,
  localparam int LEVELS = $clog2(LANES),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] fold_ctl,
  input  logic [LANES-1:0]  lane_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [LANES-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [LANES-1:0]  rsp_data
);
  vw_op_e           op;
  logic             take;
  logic [LANES-1:0] wr_lanes;
  logic [LANES-1:0] rd_lanes;
  logic [LANES-1:0] rd_pins;

  assign op        = vw_op_e'(req_write);
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  vw_spread #(.LANES(LANES)) u_spread (
    .fold (fold_ctl),
    .pins (req_wdata),
    .lanes(wr_lanes)
  );

  vw_store #(.LANES(LANES), .DEPTH(DEPTH)) u_store (
    .clk  (clk),
    .we   (take && op == OP_WRITE),
    .addr (req_addr),
    .wmask(lane_sel),
    .wbits(wr_lanes),
    .rbits(rd_lanes)
  );

  vw_gather #(.LANES(LANES)) u_gather (
    .fold (fold_ctl),
    .sel  (lane_sel),
    .lanes(rd_lanes),
    .pins (rd_pins)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take && op == OP_READ) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_pins;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vw_lane_ram_chk.sv
module vw_lane_ram_chk #(
  parameter int LANES = 16,
  localparam int LEVELS = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LEVELS-1:0] fold_ctl,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [LANES-1:0]  rsp_data
);
  logic [LEVELS-1:0] fold_inc;
  logic              fold_legal;
  logic [LANES-1:0]  pin_mask;
  logic              rd_take;
  logic              wr_take;

  assign fold_inc   = fold_ctl + LEVELS'(1);
  assign fold_legal = (fold_ctl & fold_inc) == '0;
  assign rd_take    = req_valid && req_ready && !req_write;
  assign wr_take    = req_valid && req_ready && req_write;

  always_comb begin
    for (int i = 0; i < LANES; i++)
      pin_mask[i] = (i < (LANES >> $countones(fold_ctl)));
  end

  a_r1_legal_fold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> fold_legal);

  a_r6_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> rsp_valid);

  a_r5_upper_pins_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> ((rsp_data & ~$past(pin_mask)) == '0));

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r9_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && !rsp_valid) |=> !rsp_valid);
endmodule

bind vw_lane_ram vw_lane_ram_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fold_ctl (fold_ctl),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data)
);

// File: tb/vw_lane_ram_tb_top.sv
`timescale 1ns/1ps
module vw_lane_ram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  fold_ctl = '0;
  logic [15:0] lane_sel = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;

  int errors = 0;
  int checks = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  logic [15:0] ref_mem [64];
  bit          m_valid = 1'b0;
  logic [15:0] m_data = '0;

  always #2.5 clk = ~clk;

  vw_lane_ram dut_i (
    .clk(clk), .rst_n(rst_n), .fold_ctl(fold_ctl), .lane_sel(lane_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // R1: width from the thermometer fold code
  function automatic int width_of(input logic [3:0] c);
    case (c)
      4'b0000: return 16;
      4'b0001: return 8;
      4'b0011: return 4;
      4'b0111: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, updated at each rising edge from the sampled inputs.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 1'b0;
    end else begin
      bit acc;
      int w;
      logic [15:0] word;
      logic [15:0] exp;
      w = width_of(fold_ctl);
      acc = req_valid && (!m_valid || rsp_ready);
      if (acc && req_write) begin
        for (int i = 0; i < 16; i++)
          if (lane_sel[i]) ref_mem[req_addr][i] = req_wdata[i % w];   // R2, R3
      end
      if (acc && !req_write) begin
        word = ref_mem[req_addr];
        exp = '0;
        for (int i = 0; i < 16; i++)
          if (lane_sel[i]) exp[i % w] = exp[i % w] | word[i];         // R4, R5
        m_data = exp;
        m_valid = 1'b1;
      end else if (rsp_ready) begin
        m_valid = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (running) begin
      check(rsp_valid == m_valid, "R6 R7 R9 rsp_valid", 16'(rsp_valid), 16'(m_valid));
      check(req_ready == (!m_valid || rsp_ready), "R8 req_ready", 16'(req_ready),
            16'(!m_valid || rsp_ready));
      if (m_valid) begin
        check(rsp_data[0] == m_data[0] && rsp_data[7:1] == m_data[7:1],
              "R1 R2 R3 R4 low pins", rsp_data, m_data);
        check(rsp_data[15:8] == m_data[15:8], "R5 upper pins", rsp_data, m_data);
      end
    end
  end

  task automatic pick_sel(input int w, input bit full);
    lane_sel = '0;
    for (int p = 0; p < w; p++) begin
      int grp;
      grp = $urandom_range(0, 16 / w - 1);
      if (full || $urandom_range(0, 3) != 0) lane_sel[p + w * grp] = 1'b1;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rsp_valid == 1'b0, "R10 rsp_valid after reset", 16'(rsp_valid), 16'd0);
    check(req_ready == 1'b1, "R10 req_ready after reset", 16'(req_ready), 16'd1);
    running = 1'b1;

    // Fill every location at full width with all lanes enabled.
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      fold_ctl = 4'b0000; lane_sel = 16'hFFFF; req_valid = 1'b1; req_write = 1'b1;
      req_addr = 6'(a); req_wdata = 16'($urandom); rsp_ready = 1'b1;
    end

    // Mixed traffic over all widths, random lane masks and back-pressure.
    for (int n = 0; n < 4000; n++) begin
      int idx;
      int w;
      logic [3:0] codes [5];
      codes[0] = 4'b0000; codes[1] = 4'b0001; codes[2] = 4'b0011;
      codes[3] = 4'b0111; codes[4] = 4'b1111;
      @(negedge clk);
      idx = $urandom_range(0, 4);
      w = 16 >> idx;
      fold_ctl = codes[idx];
      // Every fourth step reads the whole word at full width to expose untouched lanes (R3).
      if (n % 4 == 3) begin
        fold_ctl = 4'b0000; lane_sel = 16'hFFFF; req_write = 1'b0;
      end else begin
        pick_sel(w, $urandom_range(0, 1) == 1);
        req_write = $urandom_range(0, 1) == 1;
      end
      req_valid = $urandom_range(0, 3) != 0;
      req_addr = 6'($urandom_range(0, 7));
      req_wdata = 16'($urandom);
      rsp_ready = (n % 200 < 20) ? 1'b0 : ($urandom_range(0, 3) != 0);
    end

    @(negedge clk);
    req_valid = 1'b0; rsp_ready = 1'b1;
    repeat (4) @(negedge clk);
    running = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule